// File: doc/BRIEF.md
# Input Change Notification Detector

This block watches a 16-bit input port and reports which pins have changed level since software last read the port. Software reads the port value; at that moment the detector stores the current pin levels as a reference snapshot and clears every per-pin status flag. After the read, a status bit sets for each pin that is enabled for detection and whose level differs from its snapshot bit. The bit stays set until the next port read, even if the pin goes back to its old level.

A single interrupt request is the OR of all status bits, gated by a module enable. The request stays high until a port read clears the status. A separate wake output is driven combinationally from the mismatch between the live pin levels and the snapshot. It gives the same indication without any clock edge, which a sleeping system with stopped clocks can use. Pin levels arrive here already synchronized. The per-pin enables and the module enable come from a register bank outside this block.

Top module: `pin_change_detect`

## Requirements
- R1: While reset is asserted, `status_o`, `irq_o` and `wake_o` are all 0.
- R2: On the first clock edge after reset is released, the pin levels are stored as the snapshot and no status bit sets. A pin held steady from reset onward never sets its status bit.
- R3: At a clock edge with no read strobe, status bit i sets when `pin_en_i[i]` is 1 and `pin_i[i]` differs from snapshot bit i. A set bit stays set until a read strobe, even if the pin returns to its snapshot level.
- R4: A status bit never sets in a cycle whose `pin_en_i` bit is 0, no matter how its pin moves.
- R5: A clock edge with `port_rd_i` high clears all status bits and stores the current pin levels as the snapshot. The clear takes priority over a change seen in the same cycle.
- R6: A change is judged against the snapshot, not against the previous clock sample. A pin that moved while disabled sets its status bit once it is enabled, if it still differs from the snapshot. A pin that changed in the read cycle raises no status afterwards.
- R7: `irq_o` is registered. After each clock edge it equals `mod_en_i`, as sampled at that edge, ANDed with the OR of the new status bits. It stays high until a read clears the status.
- R8: `wake_o` is combinational. It is 1 exactly when `mod_en_i` is 1 and some enabled pin differs from its snapshot bit. It is 0 before the first snapshot after reset.
- R9: The module enable gates only `irq_o` and `wake_o`. Status bits still record changes while `mod_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Synchronized pin levels |
| pin_en_i | input | 16 | Per-pin detection enable, 1 = enabled |
| mod_en_i | input | 1 | Module enable for interrupt and wake |
| port_rd_i | input | 1 | Strobe, high for a cycle in which the port is read |
| status_o | output | 16 | Per-pin changed-since-read flags |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Combinational change indication |

## Verification
The bench goes after a pin that moves while disabled and is enabled later, still differing. A design that compares against the previous clock sample misses that change. It also drives a read in the same cycle as a pin change. A design that lets the set win over the clear leaves a stale flag, and one that keeps the old snapshot flags the pin again on the next cycle. A pin that returns to its snapshot level before the read must keep its flag, which a non-sticky design drops. Toggling the module enable exposes a design that gates the status itself rather than only the request and wake lines.

// File: rtl/cn_pkg.sv
package cn_pkg;
    typedef enum logic {
        CN_PRIME = 1'b0,
        CN_LIVE  = 1'b1
    } cn_phase_e;

    function automatic logic cn_any(input logic [63:0] vec);
        return |vec;
    endfunction
endpackage

// File: rtl/cn_reference.sv
module cn_reference #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] snap_o,
    output logic             live_o
);
    import cn_pkg::*;

    typedef struct packed {
        cn_phase_e        phase;
        logic [WIDTH-1:0] snap;
    } ref_t;

    ref_t ref_d, ref_q;

    always_comb begin
        ref_d = ref_q;
        if (ref_q.phase == CN_PRIME) begin
            ref_d.phase = CN_LIVE;
            ref_d.snap  = pin_i;
        end else if (rd_i) begin
            ref_d.snap  = pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q.phase <= CN_PRIME;
            ref_q.snap  <= '0;
        end else begin
            ref_q <= ref_d;
        end
    end

    assign snap_o = ref_q.snap;
    assign live_o = (ref_q.phase == CN_LIVE);
endmodule

// File: rtl/cn_compare.sv
module cn_compare #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             live_i,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] snap_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] diff_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign diff_o[g] = live_i & en_i[g] & (pin_i[g] ^ snap_i[g]);
    end
endmodule

// File: rtl/cn_status.sv
module cn_status #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] diff_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] status_next_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } stat_t;

    stat_t stat_d, stat_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        always_comb begin
            if (rd_i) begin
                stat_d.bits[g] = 1'b0;
            end else begin
                stat_d.bits[g] = stat_q.bits[g] | diff_i[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status_o      = stat_q.bits;
    assign status_next_o = stat_d.bits;
endmodule

// File: rtl/cn_irq.sv
module cn_irq #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en_i,
    input  logic [WIDTH-1:0] status_next_i,
    input  logic [WIDTH-1:0] diff_i,
    output logic             irq_o,
    output logic             wake_o
);
    typedef struct packed {
        logic req;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d     = irq_q;
        irq_d.req = mod_en_i & (|status_next_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o  = irq_q.req;
    assign wake_o = mod_en_i & (|diff_i);
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    input  logic [WIDTH-1:0] pin_en_i,
    input  logic             mod_en_i,
    input  logic             port_rd_i,
    output logic [WIDTH-1:0] status_o,
    output logic             irq_o,
    output logic             wake_o
);
    logic [WIDTH-1:0] snap_w;
    logic             live_w;
    logic [WIDTH-1:0] diff_w;
    logic [WIDTH-1:0] status_next_w;

    cn_reference #(.WIDTH(WIDTH)) i_reference (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rd_i   (port_rd_i),
        .snap_o (snap_w),
        .live_o (live_w)
    );

    cn_compare #(.WIDTH(WIDTH)) i_compare (
        .live_i (live_w),
        .pin_i  (pin_i),
        .snap_i (snap_w),
        .en_i   (pin_en_i),
        .diff_o (diff_w)
    );

    cn_status #(.WIDTH(WIDTH)) i_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .diff_i        (diff_w),
        .rd_i          (port_rd_i),
        .status_o      (status_o),
        .status_next_o (status_next_w)
    );

    cn_irq #(.WIDTH(WIDTH)) i_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .mod_en_i      (mod_en_i),
        .status_next_i (status_next_w),
        .diff_i        (diff_w),
        .irq_o         (irq_o),
        .wake_o        (wake_o)
    );
endmodule

// File: rtl/pin_change_detect_chk.sv
module pin_change_detect_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_en_i,
    input logic             mod_en_i,
    input logic             port_rd_i,
    input logic [WIDTH-1:0] status_o,
    input logic             irq_o,
    input logic             wake_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (status_o == '0 && !irq_o && !wake_o); // R1
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(port_rd_i)) |-> (($past(status_o) & ~status_o) == '0)); // R3

    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((status_o & ~$past(status_o) & ~$past(pin_en_i)) == '0)); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(port_rd_i)) |-> (status_o == '0)); // R5

    AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (irq_o == ($past(mod_en_i) && (|status_o)))); // R7

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en_i |-> !wake_o); // R8
endmodule

bind pin_change_detect pin_change_detect_chk #(.WIDTH(WIDTH)) i_pin_change_detect_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_en_i  (pin_en_i),
    .mod_en_i  (mod_en_i),
    .port_rd_i (port_rd_i),
    .status_o  (status_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/test_pin_change_detect.sv
`timescale 1ns/1ps
module test_pin_change_detect;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin = '0;
    logic [W-1:0] en = '0;
    logic         men = 1'b0;
    logic         rd = 1'b0;
    logic [W-1:0] status_o;
    logic         irq_o;
    logic         wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic         m_live = 1'b0;
    logic [W-1:0] m_snap = '0;
    logic [W-1:0] m_stat = '0;
    logic         m_irq = 1'b0;

    always #4 clk = ~clk;

    pin_change_detect #(.WIDTH(W)) i_pin_change_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .pin_en_i  (en),
        .mod_en_i  (men),
        .port_rd_i (rd),
        .status_o  (status_o),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    function automatic logic exp_wake(input logic [W-1:0] p, input logic [W-1:0] e, input logic me);
        return m_live & me & (|((p ^ m_snap) & e));
    endfunction

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic [W-1:0] p, input logic [W-1:0] e, input logic me, input logic r);
        if (!m_live) begin
            m_live = 1'b1;
            m_snap = p;
        end else if (r) begin
            m_snap = p;
            m_stat = '0;
        end else begin
            m_stat = m_stat | ((p ^ m_snap) & e);
        end
        m_irq = me & (|m_stat);
    endtask

    task automatic cyc(input logic [W-1:0] p, input logic [W-1:0] e,
                       input logic me, input logic r, input string tag);
        pin = p; en = e; men = me; rd = r;
        #1;
        chk({15'd0, wake_o}, {15'd0, exp_wake(p, e, me)}, tag, "wake");
        @(posedge clk);
        model_edge(p, e, me, r);
        @(negedge clk);
        chk(status_o, m_stat, tag, "status");
        chk({15'd0, irq_o}, {15'd0, m_irq}, tag, "irq");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] p0;
        logic [W-1:0] cur;
        logic [W-1:0] cen;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        p0 = 16'hA5A5;
        pin = p0; en = 16'hFFFF; men = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(status_o, '0, "R1", "status in reset");
            chk({15'd0, irq_o}, '0, "R1", "irq in reset");
            chk({15'd0, wake_o}, '0, "R1", "wake in reset");
        end
        rst_n = 1'b1;
        cyc(p0, 16'hFFFF, 1'b1, 1'b0, "R2");
        cyc(p0, 16'hFFFF, 1'b1, 1'b0, "R2");
        cyc(p0 ^ 16'h0001, 16'hFFFF, 1'b1, 1'b0, "R3");
        cyc(p0, 16'hFFFF, 1'b1, 1'b0, "R3");
        cyc(p0, 16'hFFFF, 1'b1, 1'b1, "R5");
        cyc(p0 ^ 16'hFF00, 16'h00FF, 1'b1, 1'b0, "R4");
        cyc(p0 ^ 16'hFF00, 16'h00FF, 1'b1, 1'b0, "R4");
        cyc(p0 ^ 16'hFF00, 16'hFFFF, 1'b1, 1'b0, "R6");
        cyc(p0 ^ 16'hFF10, 16'hFFFF, 1'b1, 1'b1, "R5");
        cyc(p0 ^ 16'hFF10, 16'hFFFF, 1'b1, 1'b0, "R6");
        cyc(p0 ^ 16'hFF18, 16'hFFFF, 1'b0, 1'b0, "R9");
        cyc(p0 ^ 16'hFF18, 16'hFFFF, 1'b1, 1'b0, "R7");
        cyc(p0 ^ 16'hFF18, 16'hFFFF, 1'b1, 1'b0, "R8");
        cyc(p0 ^ 16'hFF18, 16'hFFFF, 1'b1, 1'b1, "R5");
        cur = p0 ^ 16'hFF18;
        cen = 16'hFFFF;
        for (int n = 0; n < 4000; n++) begin
            cur = cur ^ ($urandom & $urandom & $urandom & $urandom);
            if (($urandom % 16) == 0) cen = $urandom;
            cyc(cur, cen, (($urandom % 8) != 0), (($urandom % 8) == 0), "R3 R7 R8 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule